// File: doc/BRIEF.md
# CPU clock mode controller

This block holds the CPU operating-mode register and chooses which clock drives the system. In the low-speed mode the oscillator clock passes straight to the system clock. In the full-speed mode the system clock comes from a separate clock input, which carries the oscillator multiplied by twelve and then halved, so it runs six times faster. The multiplier is outside this block. This block sees only its output clock and a lock flag. After every reset the controller is in the low-speed mode. Software leaves that mode in two register writes. The first write clears bit 1 and enters an intermediate idle mode. The second write clears the whole low nibble and requests full speed.

The request to reach full speed is honoured only after the lock flag has stayed high for a parameterised number of consecutive slow-clock cycles. Until then the register still reads as idle. The clock switch itself is glitch-free. Each source is gated by an enable that changes only on that source's falling edge, and the new source is enabled only after two of its own rising edges have passed. The controller also drives an enable for the on-screen display, which cannot run on the slow clock. It drives a flag that tells PWM-timed peripherals that slow timing is in force.

Top module: `cpu_clk_mode_ctrl`

## Requirements
- R1: After reset the mode is slow: `modeStatus` is 2'b10, a register read returns 16'h0003, `clkIsFast` is 0 and `sysClk` follows `slowClk`.
- R2: In slow mode, a register write whose bit 1 is 0 and whose bits 3:0 are not all zero moves the mode to idle on the next slow-clock edge: `modeStatus` becomes 2'b01 and a read returns 16'h0001.
- R3: In slow mode, a register write with bits 3:0 all zero is ignored and the mode stays slow.
- R4: In idle mode, a register write with bits 3:0 all zero requests full speed. The mode becomes normal (`modeStatus` 2'b00, read 16'h0000) on the SETTLE_CYCLES-th consecutive slow-clock edge with `lockIn` high after the write. Until then the status and the read report idle.
- R5: A slow-clock edge with `lockIn` low while full speed is pending restarts the settle count. Normal is then reached only after SETTLE_CYCLES further consecutive edges with `lockIn` high.
- R6: A register write with bit 1 set returns the mode to slow from idle, from a pending request or from normal. In normal mode, any other write is ignored.
- R7: `osdEnable` is 1 exactly when the mode is normal. `pwmSlowTiming` is 1 exactly when it is not.
- R8: The two clock-source enables are never high together. After entering normal, `sysClk` carries the fast clock and `clkIsFast` is 1 within five slow cycles. After returning to slow, `sysClk` carries the slow clock again within five slow cycles.
- R9: Writes to any address other than REG_ADDR (16'hFC00 by default) have no effect. Reads of other addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slowClk | input | 1 | Oscillator clock; also clocks the register bus |
| fastClk | input | 1 | Multiplied-and-halved clock from the external multiplier |
| rstN | input | 1 | Asynchronous active-low reset |
| lockIn | input | 1 | Multiplier lock flag, synchronous to slowClk |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register bus address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid in the same cycle as rdEn |
| sysClk | output | 1 | Selected system clock |
| clkIsFast | output | 1 | Fast source currently gated onto sysClk |
| modeStatus | output | 2 | 00 normal, 01 idle, 10 slow |
| osdEnable | output | 1 | Display enable, high in normal mode only |
| pwmSlowTiming | output | 1 | High whenever PWM peripherals must use slow timing |

## Verification
The properties assume that both clocks run freely from time zero. They also assume that the bus strobes, address, data and `lockIn` are synchronous to `slowClk`, so each is stable around every rising edge. The bench meets these conditions by changing every input only on the falling edge of `slowClk`. It holds each strobe for a single cycle, and it runs the fast clock continuously at six times the slow rate. The exclusivity of the two source enables is checked on slow-clock edges. The bench adds to that check by counting `sysClk` edges in fixed windows.

// File: rtl/cpu_clk_mode_pkg.sv
package cpu_clk_mode_pkg;

  // Externally visible mode encoding
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_IDLE   = 2'b01,
    MODE_SLOW   = 2'b10
  } modeCode_t;

  // Internal control states; WAIT_LOCK reports as idle
  typedef enum logic [1:0] {
    ST_SLOW,
    ST_IDLE,
    ST_WAIT_LOCK,
    ST_NORMAL
  } ctlState_t;

  // Strobes from control to the clock datapath
  typedef struct packed {
    logic selFast;
  } clkStrobe_t;

  localparam int SRC_COUNT = 2;
  localparam int SRC_SLOW  = 0;
  localparam int SRC_FAST  = 1;

  // Low-nibble readback per mode
  localparam logic [3:0] NIB_SLOW   = 4'b0011;
  localparam logic [3:0] NIB_IDLE   = 4'b0001;
  localparam logic [3:0] NIB_NORMAL = 4'b0000;

endpackage

// File: rtl/cpu_clk_mode_branch.sv
// One gated clock source: two rising-edge synchronizers, then an
// enable flop on the falling edge so the gate never cuts a high phase.
module cpu_clk_mode_branch #(
  parameter bit EN_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic req,
  output logic en
);
  logic [1:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= {2{EN_AT_RESET}};
    else       syncQ <= {syncQ[0], req};
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) en <= EN_AT_RESET;
    else       en <= syncQ[1];
  end
endmodule

// File: rtl/cpu_clk_mode_clkmux.sv
// Glitch-free two-source clock selector (datapath).
module cpu_clk_mode_clkmux
  import cpu_clk_mode_pkg::*;
(
  input  logic       slowClk,
  input  logic       fastClk,
  input  logic       rstN,
  input  clkStrobe_t strobe,
  output logic       sysClk,
  output logic       slowActive,
  output logic       fastActive
);
  logic [SRC_COUNT-1:0] srcClk;
  logic [SRC_COUNT-1:0] srcReq;
  logic [SRC_COUNT-1:0] srcEn;
  logic [SRC_COUNT-1:0] wantSrc;

  assign srcClk[SRC_SLOW]  = slowClk;
  assign srcClk[SRC_FAST]  = fastClk;
  assign wantSrc[SRC_SLOW] = ~strobe.selFast;
  assign wantSrc[SRC_FAST] = strobe.selFast;

  // A source may request its gate only while every other gate is closed
  always_comb begin
    for (int i = 0; i < SRC_COUNT; i++) begin
      srcReq[i] = wantSrc[i];
      for (int j = 0; j < SRC_COUNT; j++) begin
        if (j != i) srcReq[i] = srcReq[i] & ~srcEn[j];
      end
    end
  end

  for (genvar g = 0; g < SRC_COUNT; g++) begin : g_branch
    cpu_clk_mode_branch #(
      .EN_AT_RESET(g == SRC_SLOW)
    ) u_branch (
      .clk (srcClk[g]),
      .rstN(rstN),
      .req (srcReq[g]),
      .en  (srcEn[g])
    );
  end

  assign sysClk     = |(srcClk & srcEn);
  assign slowActive = srcEn[SRC_SLOW];
  assign fastActive = srcEn[SRC_FAST];
endmodule

// File: rtl/cpu_clk_mode_ctl.sv
// Mode register, transition ordering and lock settle counter (control).
module cpu_clk_mode_ctl
  import cpu_clk_mode_pkg::*;
#(
  parameter int              ADDR_W        = 16,
  parameter int              DATA_W        = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 16'hFC00,
  parameter int              SETTLE_CYCLES = 16
) (
  input  logic              slowClk,
  input  logic              rstN,
  input  logic              lockIn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output clkStrobe_t        strobe,
  output logic [1:0]        modeStatus,
  output logic              osdEnable,
  output logic              pwmSlowTiming
);
  localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  ctlState_t         state, stateNext;
  logic [CNT_W-1:0]  settleCnt, settleCntNext;
  logic              regHit, wrHit, wrToSlow, wrToIdle, wrToNormal;
  logic [3:0]        wrNib, rdNib;

  assign regHit     = (addr == REG_ADDR);
  assign wrHit      = wrEn & regHit;
  assign wrNib      = wrData[3:0];
  assign wrToSlow   = wrHit & wrNib[1];
  assign wrToIdle   = wrHit & ~wrNib[1] & (wrNib != 4'b0000);
  assign wrToNormal = wrHit & (wrNib == 4'b0000);

  always_comb begin
    stateNext     = state;
    settleCntNext = '0;
    unique case (state)
      ST_SLOW: begin
        if (wrToIdle) stateNext = ST_IDLE;
      end
      ST_IDLE: begin
        if (wrToSlow)        stateNext = ST_SLOW;
        else if (wrToNormal) stateNext = ST_WAIT_LOCK;
      end
      ST_WAIT_LOCK: begin
        if (wrToSlow) begin
          stateNext = ST_SLOW;
        end else if (lockIn) begin
          if (settleCnt == CNT_LAST) stateNext = ST_NORMAL;
          else settleCntNext = settleCnt + 1'b1;
        end
      end
      ST_NORMAL: begin
        if (wrToSlow) stateNext = ST_SLOW;
      end
      default: stateNext = ST_SLOW;
    endcase
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_SLOW;
      settleCnt <= '0;
    end else begin
      state     <= stateNext;
      settleCnt <= settleCntNext;
    end
  end

  always_comb begin
    unique case (state)
      ST_SLOW:   begin modeStatus = MODE_SLOW;   rdNib = NIB_SLOW;   end
      ST_NORMAL: begin modeStatus = MODE_NORMAL; rdNib = NIB_NORMAL; end
      default:   begin modeStatus = MODE_IDLE;   rdNib = NIB_IDLE;   end
    endcase
  end

  assign rdData         = (rdEn && regHit) ? DATA_W'(rdNib) : '0;
  assign strobe.selFast = (state == ST_NORMAL);
  assign osdEnable      = (state == ST_NORMAL);
  assign pwmSlowTiming  = (state != ST_NORMAL);
endmodule

// File: rtl/cpu_clk_mode_ctrl.sv
module cpu_clk_mode_ctrl
  import cpu_clk_mode_pkg::*;
#(
  parameter int                ADDR_W        = 16,
  parameter int                DATA_W        = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR      = 16'hFC00,
  parameter int                SETTLE_CYCLES = 16
) (
  input  logic              slowClk,
  input  logic              fastClk,
  input  logic              rstN,
  input  logic              lockIn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sysClk,
  output logic              clkIsFast,
  output logic [1:0]        modeStatus,
  output logic              osdEnable,
  output logic              pwmSlowTiming
);
  clkStrobe_t strobe;
  logic       slowActive;
  logic       fastActive;

  cpu_clk_mode_ctl #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .REG_ADDR     (REG_ADDR),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctl (
    .slowClk      (slowClk),
    .rstN         (rstN),
    .lockIn       (lockIn),
    .wrEn         (wrEn),
    .rdEn         (rdEn),
    .addr         (addr),
    .wrData       (wrData),
    .rdData       (rdData),
    .strobe       (strobe),
    .modeStatus   (modeStatus),
    .osdEnable    (osdEnable),
    .pwmSlowTiming(pwmSlowTiming)
  );

  cpu_clk_mode_clkmux u_mux (
    .slowClk   (slowClk),
    .fastClk   (fastClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sysClk    (sysClk),
    .slowActive(slowActive),
    .fastActive(fastActive)
  );

  assign clkIsFast = fastActive;
endmodule

// File: rtl/cpu_clk_mode_ctrl_chk.sv
module cpu_clk_mode_ctrl_chk #(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFC00
) (
  input logic              slowClk,
  input logic              rstN,
  input logic              lockIn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [1:0]        modeStatus,
  input logic              osdEnable,
  input logic              pwmSlowTiming,
  input logic              slowActive,
  input logic              fastActive
);
  logic regWr;
  assign regWr = wrEn && (addr == REG_ADDR);

  a_r2_slow_to_idle: assert property (@(posedge slowClk) disable iff (!rstN)
    (modeStatus == 2'b10 && regWr && !wrData[1] && wrData[3:0] != 4'b0000)
      |=> modeStatus == 2'b01);

  a_r3_no_skip: assert property (@(posedge slowClk) disable iff (!rstN)
    (modeStatus == 2'b10 && regWr && wrData[3:0] == 4'b0000)
      |=> modeStatus == 2'b10);

  a_r4_normal_from_idle: assert property (@(posedge slowClk) disable iff (!rstN)
    (modeStatus == 2'b00 && $past(modeStatus) != 2'b00)
      |-> ($past(modeStatus) == 2'b01 && $past(lockIn)));

  a_r5_no_normal_unlocked: assert property (@(posedge slowClk) disable iff (!rstN)
    (modeStatus == 2'b01 && !lockIn) |=> modeStatus != 2'b00);

  a_r6_return_slow: assert property (@(posedge slowClk) disable iff (!rstN)
    (regWr && wrData[1]) |=> modeStatus == 2'b10);

  a_r7_osd_only_normal: assert property (@(posedge slowClk) disable iff (!rstN)
    (osdEnable == (modeStatus == 2'b00)) && (pwmSlowTiming == !osdEnable));

  a_r8_one_source: assert property (@(posedge slowClk) disable iff (!rstN)
    !(slowActive && fastActive));
endmodule

bind cpu_clk_mode_ctrl cpu_clk_mode_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .REG_ADDR(REG_ADDR)
) u_chk (
  .slowClk      (slowClk),
  .rstN         (rstN),
  .lockIn       (lockIn),
  .wrEn         (wrEn),
  .addr         (addr),
  .wrData       (wrData),
  .modeStatus   (modeStatus),
  .osdEnable    (osdEnable),
  .pwmSlowTiming(pwmSlowTiming),
  .slowActive   (slowActive),
  .fastActive   (fastActive)
);

// File: tb/test_cpu_clk_mode_ctrl.sv
`timescale 1ns/1ps
module test_cpu_clk_mode_ctrl;
  localparam int SETTLE = 6;
  localparam logic [15:0] REGA = 16'hFC00;

  logic slowClk = 1'b0;
  logic fastClk = 1'b0;
  logic rstN = 1'b0;
  logic lockIn = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic sysClk, clkIsFast, osdEnable, pwmSlowTiming;
  logic [1:0] modeStatus;

  int nChecks = 0;
  int nFails = 0;
  int sysEdges = 0;

  always #4 slowClk = ~slowClk;          // 125 MHz
  always #0.666 fastClk = ~fastClk;      // six times faster
  always @(posedge sysClk) sysEdges++;

  cpu_clk_mode_ctrl #(.SETTLE_CYCLES(SETTLE)) i_cpu_clk_mode_ctrl (
    .slowClk(slowClk), .fastClk(fastClk), .rstN(rstN), .lockIn(lockIn),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .sysClk(sysClk), .clkIsFast(clkIsFast), .modeStatus(modeStatus),
    .osdEnable(osdEnable), .pwmSlowTiming(pwmSlowTiming)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge slowClk);
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [15:0] d);
    @(negedge slowClk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge slowClk);
    wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  task automatic busRead(input logic [15:0] a, output int v);
    rdEn = 1'b1; addr = a;
    #1 v = rdData;
    rdEn = 1'b0; addr = '0;
  endtask

  // Count sysClk rising edges over two slow cycles
  task automatic edgeWindow(output int n);
    int s;
    @(negedge slowClk);
    s = sysEdges;
    tick(2);
    n = sysEdges - s;
  endtask

  task automatic doReset();
    rstN = 1'b0; lockIn = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic goNormal();
    lockIn = 1'b1;
    busWrite(REGA, 16'hFFFD);
    busWrite(REGA, 16'hFFF0);
    tick(SETTLE);
  endtask

  task automatic t_reset();
    int v, e;
    doReset();
    check("R1", "status", modeStatus, 2);
    busRead(REGA, v);
    check("R1", "readback", v, 16'h0003);
    check("R1", "clkIsFast", clkIsFast, 0);
    edgeWindow(e);
    check("R1", "sysClk edges", e, 2);
    check("R7", "osd in slow", osdEnable, 0);
    check("R7", "pwm slow flag", pwmSlowTiming, 1);
  endtask

  task automatic t_skip();
    doReset();
    lockIn = 1'b1;
    busWrite(REGA, 16'hFFF0);
    check("R3", "direct write ignored", modeStatus, 2);
    tick(SETTLE + 2);
    check("R3", "still slow later", modeStatus, 2);
  endtask

  task automatic t_idleAndSettle();
    int v;
    doReset();
    lockIn = 1'b1;
    busWrite(REGA, 16'hFFFD);
    check("R2", "idle status", modeStatus, 1);
    busRead(REGA, v);
    check("R2", "idle readback", v, 16'h0001);
    busWrite(REGA, 16'hFFF0);
    check("R4", "pending reads idle", modeStatus, 1);
    tick(SETTLE - 1);
    check("R4", "one edge short", modeStatus, 1);
    busRead(REGA, v);
    check("R4", "pending readback", v, 16'h0001);
    tick(1);
    check("R4", "normal reached", modeStatus, 0);
    busRead(REGA, v);
    check("R4", "normal readback", v, 16'h0000);
    check("R7", "osd in normal", osdEnable, 1);
    check("R7", "pwm flag in normal", pwmSlowTiming, 0);
  endtask

  task automatic t_lockDrop();
    doReset();
    lockIn = 1'b1;
    busWrite(REGA, 16'hFFFD);
    busWrite(REGA, 16'hFFF0);
    tick(3);
    lockIn = 1'b0;
    tick(1);
    lockIn = 1'b1;
    tick(SETTLE - 1);
    check("R5", "count restarted", modeStatus, 1);
    tick(1);
    check("R5", "normal after restart", modeStatus, 0);
  endtask

  task automatic t_returnSlow();
    doReset();
    lockIn = 1'b1;
    busWrite(REGA, 16'hFFFD);
    busWrite(REGA, 16'h0002);
    check("R6", "idle to slow", modeStatus, 2);
    busWrite(REGA, 16'hFFFD);
    busWrite(REGA, 16'hFFF0);
    tick(2);
    busWrite(REGA, 16'h0003);
    check("R6", "pending to slow", modeStatus, 2);
    goNormal();
    busWrite(REGA, 16'h0001);
    check("R6", "idle pattern ignored in normal", modeStatus, 0);
    busWrite(REGA, 16'h0002);
    check("R6", "normal to slow", modeStatus, 2);
    check("R7", "osd cleared", osdEnable, 0);
  endtask

  task automatic t_clockSwitch();
    int e;
    doReset();
    goNormal();
    check("R8", "normal entered", modeStatus, 0);
    tick(5);
    check("R8", "fast selected", clkIsFast, 1);
    edgeWindow(e);
    check("R8", "fast edges in range", int'(e >= 11 && e <= 13), 1);
    busWrite(REGA, 16'h0002);
    tick(5);
    check("R8", "fast released", clkIsFast, 0);
    edgeWindow(e);
    check("R8", "slow edges", e, 2);
  endtask

  task automatic t_otherAddr();
    int v;
    doReset();
    lockIn = 1'b1;
    busWrite(16'hFC02, 16'hFFFD);
    check("R9", "foreign write ignored in slow", modeStatus, 2);
    busWrite(REGA, 16'hFFFD);
    busWrite(16'h0C00, 16'h0000);
    tick(SETTLE + 2);
    check("R9", "foreign write ignored in idle", modeStatus, 1);
    busRead(16'hFC01, v);
    check("R9", "foreign read zero", v, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_skip();
        t_idleAndSettle();
        t_lockDrop();
        t_returnSlow();
        t_clockSwitch();
        t_otherAddr();
      end
      begin
        repeat (20000) @(posedge slowClk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule